// File: doc/BRIEF.md
# Two-Phase Scaled PWM Generator

This block drives one pulse-width modulated output. Its timing is built from a programmable base unit, measured in system clock cycles, and two 8-bit counts of base units. The high count sets how long the output stays active in each period and the low count sets how long it stays inactive. A period therefore lasts the base unit times the sum of the two counts, and its on time lasts the base unit times the high count.

A polarity bit chooses the order of the two phases. With the bit clear, every period opens with the active (high) phase. With the bit set, every period opens with the inactive (low) phase and ends with the active one. The base unit, both counts and the polarity bit are copied into holding registers that refresh only when a period completes. A change written mid-period therefore never cuts a phase short. Dropping the enable parks the output low and clears all counters, so the next enable begins a clean period.

Top module: `pwm2ph_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, `pwm_out` is 0. After reset the block behaves exactly as it does after a disabled clock.
- R2: One base unit lasts `unit_len` clock cycles. A `unit_len` of 0 is treated as one cycle.
- R3: With both counts nonzero, the period lasts (`hi_cnt` + `lo_cnt`) base units. When both counts are zero the period is one base unit long.
- R4: The output is 1 for exactly `hi_cnt` base units of each period. Active means logic 1.
- R5: With `invert` = 0, the first enabled clock of each period shows the high phase, and the low phase follows it.
- R6: With `invert` = 1, each period starts with `lo_cnt` units at 0 and then has `hi_cnt` units at 1.
- R7: `hi_cnt` = 0 holds the output at 0. `lo_cnt` = 0 with a nonzero `hi_cnt` holds it at 1. Both counts at zero hold it at 0.
- R8: The configuration inputs are sampled only on the clock edge that ends a period, and on every edge at which `enable` is 0. A change made mid-period first shows on the clock after the current period's last clock.
- R9: The clock after `enable` is sampled 0, `pwm_out` is 0. The first clock with `enable` sampled 1 is clock 0 of a new period, using the configuration present on the last disabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the generator. When 0, the output is parked low |
| unit_len | input | 16 | Base unit length in clock cycles (0 acts as 1) |
| hi_cnt | input | 8 | Active phase length in base units |
| lo_cnt | input | 8 | Inactive phase length in base units |
| invert | input | 1 | 1 makes each period start with the inactive phase |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest case to reach from the ports is a configuration change that arrives in the middle of a period. Checking it needs the old phase to finish at full length and the new values to show up on exactly the following clock. The bench starts a long period, rewrites every configuration input a few clocks in, and keeps a cycle-accurate model. The model holds its own copy of the latched values and refreshes that copy only at period ends, so any early pickup shows as a miscompare. A disable in mid-phase and a reset while running are also driven, and each is checked to restart from clock 0 of a period.

// File: rtl/pwm2ph_pkg.sv
package pwm2ph_pkg;

  // Which of the two phases of a period is being emitted
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;

endpackage

// File: rtl/pwm2ph_shadow.sv
module pwm2ph_shadow #(
  parameter int UNIT_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              period_end,
  input  logic [UNIT_W-1:0] unit_in,
  input  logic [CNT_W-1:0]  hi_in,
  input  logic [CNT_W-1:0]  lo_in,
  input  logic              inv_in,
  output logic [UNIT_W-1:0] unit_sh,
  output logic [CNT_W-1:0]  hi_sh,
  output logic [CNT_W-1:0]  lo_sh,
  output logic              inv_sh
);

  logic take;
  assign take = rst || !enable || period_end;

  always_ff @(posedge clk) begin
    if (take) begin
      unit_sh <= unit_in;
      hi_sh   <= hi_in;
      lo_sh   <= lo_in;
      inv_sh  <= inv_in;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && !period_end) |=> ($stable(hi_sh) && $stable(lo_sh) &&
                                 $stable(unit_sh) && $stable(inv_sh))); // R8

endmodule

// File: rtl/pwm2ph_prescale.sv
module pwm2ph_prescale #(
  parameter int UNIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [UNIT_W-1:0] unit_len,
  output logic              tick
);

  logic [UNIT_W-1:0] div_cnt;
  logic [UNIT_W-1:0] last_val;

  // A zero unit behaves as a one-cycle unit
  assign last_val = (unit_len == '0) ? '0 : unit_len - 1'b1;
  assign tick     = enable && (div_cnt == last_val);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      div_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    enable |-> (div_cnt <= last_val)); // R2

  AST_DIV_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (div_cnt == '0)); // R9

endmodule

// File: rtl/pwm2ph_phase.sv
module pwm2ph_phase
  import pwm2ph_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic             invert,
  output logic             period_end,
  output logic             pwm_out
);

  localparam int EXT_W = CNT_W + 1;

  phase_e           ph_q;
  phase_e           ph_eff;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_a;
  logic [CNT_W-1:0] len_b;
  logic [CNT_W-1:0] len_cur;
  logic             both_zero;
  logic             ph_last;
  logic             level;

  // Phase A is emitted first in a period; polarity picks which count it uses
  assign len_a     = invert ? lo_cnt : hi_cnt;
  assign len_b     = invert ? hi_cnt : lo_cnt;
  assign both_zero = (hi_cnt == '0) && (lo_cnt == '0);
  assign ph_eff    = (len_a == '0) ? PH_SECOND : ph_q;
  assign len_cur   = (ph_eff == PH_FIRST) ? len_a : len_b;
  assign ph_last   = tick && ({1'b0, cnt_q} == ({1'b0, len_cur} - EXT_W'(1)));

  assign period_end = enable && tick &&
                      (both_zero || (ph_last && ((ph_eff == PH_SECOND) || (len_b == '0))));

  always_comb begin
    if (hi_cnt == '0)      level = 1'b0;
    else if (lo_cnt == '0) level = 1'b1;
    else                   level = (ph_eff == PH_FIRST) ? ~invert : invert;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      ph_q    <= PH_FIRST;
      cnt_q   <= '0;
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= level;
      if (period_end) begin
        ph_q  <= PH_FIRST;
        cnt_q <= '0;
      end else if (ph_last) begin
        ph_q  <= PH_SECOND;
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (enable && !both_zero) |-> (cnt_q < len_cur)); // R3

  AST_HI_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    (enable && hi_cnt == '0) |=> !pwm_out); // R7

  AST_LO_ZERO_HIGH: assert property (@(posedge clk) disable iff (rst)
    (enable && lo_cnt == '0 && hi_cnt != '0) |=> pwm_out); // R7

  AST_OPEN_PHASE: assert property (@(posedge clk) disable iff (rst)
    (enable && cnt_q == '0 && ph_q == PH_FIRST && hi_cnt != '0 && lo_cnt != '0)
      |=> (pwm_out == ~invert)); // R5

endmodule

// File: rtl/pwm2ph_gen.sv
module pwm2ph_gen #(
  parameter int UNIT_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [UNIT_W-1:0] unit_len,
  input  logic [CNT_W-1:0]  hi_cnt,
  input  logic [CNT_W-1:0]  lo_cnt,
  input  logic              invert,
  output logic              pwm_out
);

  logic [UNIT_W-1:0] unit_sh;
  logic [CNT_W-1:0]  hi_sh;
  logic [CNT_W-1:0]  lo_sh;
  logic              inv_sh;
  logic              tick;
  logic              period_end;

  pwm2ph_shadow #(.UNIT_W(UNIT_W), .CNT_W(CNT_W)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .period_end (period_end),
    .unit_in    (unit_len),
    .hi_in      (hi_cnt),
    .lo_in      (lo_cnt),
    .inv_in     (invert),
    .unit_sh    (unit_sh),
    .hi_sh      (hi_sh),
    .lo_sh      (lo_sh),
    .inv_sh     (inv_sh)
  );

  pwm2ph_prescale #(.UNIT_W(UNIT_W)) u_prescale (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .unit_len (unit_sh),
    .tick     (tick)
  );

  pwm2ph_phase #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .tick       (tick),
    .hi_cnt     (hi_sh),
    .lo_cnt     (lo_sh),
    .invert     (inv_sh),
    .period_end (period_end),
    .pwm_out    (pwm_out)
  );

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pwm_out); // R9

endmodule

// File: tb/pwm2ph_gen_bench.sv
module pwm2ph_gen_bench;

  localparam int NV = 8;
  localparam int V_UNIT [NV] = '{1, 0, 3, 2, 2, 1, 1, 4};
  localparam int V_HI   [NV] = '{3, 2, 4, 0, 5, 0, 255, 1};
  localparam int V_LO   [NV] = '{5, 2, 2, 5, 0, 0, 1, 1};
  localparam int V_INV  [NV] = '{0, 0, 1, 0, 1, 0, 0, 1};
  localparam int V_CYC  [NV] = '{40, 30, 60, 30, 30, 20, 600, 50};
  localparam string V_TAG [NV] = '{"R3 R4 R5", "R2", "R6", "R7",
                                   "R7", "R7", "R4", "R6"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] unit_len = 16'd1;
  logic [7:0]  hi_cnt = 8'd0;
  logic [7:0]  lo_cnt = 8'd0;
  logic        invert = 1'b0;
  logic        pwm_out;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int m_pos = 0;
  int m_u = 1, m_h = 0, m_l = 0, m_i = 0;

  always #2 clk = ~clk;

  pwm2ph_gen u_pwm2ph_gen (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .unit_len (unit_len),
    .hi_cnt   (hi_cnt),
    .lo_cnt   (lo_cnt),
    .invert   (invert),
    .pwm_out  (pwm_out)
  );

  function automatic int ueff(int u);
    return (u == 0) ? 1 : u;
  endfunction

  function automatic int per_len(int u, int h, int l);
    return ((h + l) == 0) ? ueff(u) : (h + l) * ueff(u);
  endfunction

  function automatic logic exp_level(int u, int h, int l, int inv, int pos);
    int first;
    if (h == 0) return 1'b0;
    if (l == 0) return 1'b1;
    first = (inv != 0) ? l : h;
    if (pos < first * ueff(u)) return (inv != 0) ? 1'b0 : 1'b1;
    return (inv != 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic check(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
    end
  endtask

  task automatic load_model();
    m_pos = 0;
    m_u = unit_len; m_h = hi_cnt; m_l = lo_cnt; m_i = invert;
  endtask

  // One clock: inputs are stable from the preceding negedge
  task automatic step(string tag);
    logic e;
    @(posedge clk);
    #1;
    if (rst || !enable) begin
      e = 1'b0;
      load_model();
    end else begin
      e = exp_level(m_u, m_h, m_l, m_i, m_pos);
      m_pos++;
      if (m_pos == per_len(m_u, m_h, m_l)) load_model();
    end
    check(tag, pwm_out, e);
    @(negedge clk);
  endtask

  task automatic set_cfg(int u, int h, int l, int inv);
    unit_len = 16'(u); hi_cnt = 8'(h); lo_cnt = 8'(l); invert = inv[0];
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step("R1");
    step("R1");
    rst = 1'b0;
    step("R1");

    // table walk: configure while idle, then run
    for (int v = 0; v < NV; v++) begin
      enable = 1'b0;
      set_cfg(V_UNIT[v], V_HI[v], V_LO[v], V_INV[v]);
      step("R9");
      enable = 1'b1;
      for (int c = 0; c < V_CYC[v]; c++) step(V_TAG[v]);
    end

    // mid-period change: must wait for the period boundary
    enable = 1'b0;
    set_cfg(2, 6, 6, 0);
    step("R9");
    enable = 1'b1;
    for (int c = 0; c < 5; c++) step("R8");
    set_cfg(1, 1, 4, 1);
    for (int c = 0; c < 60; c++) step("R8");
    set_cfg(3, 2, 3, 0);
    for (int c = 0; c < 7; c++) step("R8");
    set_cfg(0, 2, 1, 0);
    for (int c = 0; c < 60; c++) step("R8");

    // disable in mid-phase, then restart from a fresh period
    set_cfg(2, 4, 4, 0);
    for (int c = 0; c < 40; c++) step("R9");
    for (int c = 0; c < 3; c++) step("R9");
    enable = 1'b0;
    step("R9");
    step("R9");
    enable = 1'b1;
    for (int c = 0; c < 40; c++) step("R9");

    // reset while running
    for (int c = 0; c < 5; c++) step("R1");
    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    for (int c = 0; c < 30; c++) step("R1");

    finish_run();
  end

endmodule